// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a small set of configuration registers that exist once per hardware unit. The units are arranged as groups, each with a number of instances, and every copy of a given register answers at the same single word address. A steering selector register picks the target group and instance and carries a broadcast bit. Writes to a replicated register go either to every available copy at once (broadcast) or to only the steered copy. Reads always return the one steered copy.

A per-instance availability mask models units that are fused off or power gated. An access steered to such a unit ends quietly. A read returns zero and a write is dropped, and the handshake still completes. Two agents, a host and a firmware agent, share the selector. A hardware lock word, taken by reading it, makes sure only the current owner can reprogram the steering. Requests use a valid/ready handshake, and the response comes back one cycle later.

Top module: `repl_reg_steer`

## Requirements
- R1: The selector sits at word address 0. Group is bits [2:0], instance is bits [5:3] and the broadcast flag is bit 6. It reads back as written, and after reset it reads 0 (group 0, instance 0, unicast).
- R2: A write to a replicated register with the broadcast flag set stores the data in every instance whose availability bit is 1. The availability bit for group g and instance i is at index g*NUM_INST+i.
- R3: A write with the broadcast flag clear changes only the steered instance. Every other instance keeps its value.
- R4: A read of a replicated register returns the steered instance alone, whether the broadcast flag is set or clear.
- R5: A read steered to an unavailable instance, or to a group or instance number past the configured count, returns zero.
- R6: A unicast write steered to an unavailable instance is dropped. The copy holds its old value once it becomes available again.
- R7: A broadcast write leaves every unavailable instance unchanged.
- R8: The lock word is at address 1. A read while it is free returns 1 and makes the reading agent the owner. A read while it is held returns 0 and changes nothing.
- R9: When the owner writes 0 to the lock word, the lock is freed. A write to the lock word by the other agent has no effect.
- R10: A selector write takes effect only when the writing agent owns the lock. Otherwise it is ignored.
- R11: req_ready is high whenever no response is pending. An accepted request, including a terminated one, raises rsp_valid for exactly the next cycle.
- R12: Replicated registers sit at addresses 2 up to 2+NUM_REGS-1, each with its own reset-to-zero copies. Other addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_agent | input | 1 | Requesting agent (0 host, 1 firmware) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| avail_mask | input | NUM_GROUPS*NUM_INST | Per-instance availability, 1 = usable |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_rdata | output | DATA_W | Read data, zero for writes and terminated reads |

## Verification
Broadcast and unicast writes are mixed at several steering targets. A later unicast read at a different target shows whether a write spilled into other copies, or whether the read wrongly followed the broadcast flag. The availability mask has two holes and is later opened fully. Reading the former holes then separates a dropped write, and a broadcast that skipped the holes, from a copy that was overwritten. The lock is passed between both agents, and selector writes are tried from the non-owner. This shows whether ownership, and not just the lock being taken, gates steering changes.

// File: rtl/repl_steer_pkg.sv
package repl_steer_pkg;

    // Steering selector layout: bit 6 broadcast, [5:3] instance, [2:0] group
    typedef struct packed {
        logic       bcast;
        logic [2:0] inst;
        logic [2:0] grp;
    } steer_sel_t;

    localparam int SEL_BITS = $bits(steer_sel_t);
    localparam int MAX_PER_FIELD = 8;

endpackage

// File: rtl/repl_steer_ctrl.sv
module repl_steer_ctrl
    import repl_steer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc,
    input  logic                wr,
    input  logic                agent,
    input  logic                hit_sel,
    input  logic                hit_lock,
    input  logic [SEL_BITS-1:0] sel_wdata,
    input  logic                wdata_zero,
    output steer_sel_t          sel,
    output logic                lock_grant
);

    typedef struct packed {
        steer_sel_t sel;
        logic       busy;
        logic       owner;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     is_owner;

    always_comb begin
        st_d       = st_q;
        is_owner   = st_q.busy && (st_q.owner == agent);
        lock_grant = acc && !wr && hit_lock && !st_q.busy;
        if (lock_grant) begin
            st_d.busy  = 1'b1;
            st_d.owner = agent;
        end
        if (acc && wr && hit_lock && is_owner && wdata_zero) begin
            st_d.busy = 1'b0;
        end
        if (acc && wr && hit_sel && is_owner) begin
            st_d.sel = steer_sel_t'(sel_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel = st_q.sel;

    // R10
    non_owner_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr && hit_sel && !(st_q.busy && st_q.owner == agent)) |=> $stable(st_q.sel));

    // R8
    held_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !wr && hit_lock && st_q.busy) |=> (st_q.busy && $stable(st_q.owner)));

    // R8
    grant_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_grant |=> (st_q.busy && st_q.owner == $past(agent)));

endmodule

// File: rtl/repl_store.sv
module repl_store #(
    parameter int NUM_REGS  = 2,
    parameter int NUM_SLOTS = 16,
    parameter int DATA_W    = 32,
    parameter int REG_W     = 1,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 bcast,
    input  logic [REG_W-1:0]     reg_idx,
    input  logic [IDX_W-1:0]     tgt_idx,
    input  logic                 tgt_ok,
    input  logic [NUM_SLOTS-1:0] avail,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata
);

    typedef struct packed {
        logic [NUM_REGS-1:0][NUM_SLOTS-1:0][DATA_W-1:0] mem;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (avail[k] && (bcast || (tgt_ok && IDX_W'(k) == tgt_idx))) begin
                    st_d.mem[reg_idx][k] = wdata;
                end
            end
        end
        rdata = (tgt_ok && avail[tgt_idx]) ? st_q.mem[reg_idx][tgt_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
            // R6 R7
            gated_copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !avail[k] |=> $stable(st_q.mem[r][k]));
        end
    end

endmodule

// File: rtl/repl_reg_steer.sv
module repl_reg_steer
    import repl_steer_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int NUM_INST   = 4,
    parameter int NUM_REGS   = 2,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic                           req_write,
    input  logic                           req_agent,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [DATA_W-1:0]              req_wdata,
    input  logic [NUM_GROUPS*NUM_INST-1:0] avail_mask,
    output logic                           rsp_valid,
    output logic [DATA_W-1:0]              rsp_rdata
);

    localparam int NUM_SLOTS = NUM_GROUPS * NUM_INST;
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int REG_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] SEL_ADDR   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] LOCK_ADDR  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] REPL_BASE  = ADDR_W'(2);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] rdata;
    } rsp_st_t;

    rsp_st_t           rsp_d, rsp_q;
    logic              fire, hit_sel, hit_lock, hit_repl, tgt_ok, lock_grant;
    logic [ADDR_W-1:0] repl_off;
    logic [REG_W-1:0]  reg_idx;
    logic [IDX_W-1:0]  tgt_idx;
    logic [DATA_W-1:0] store_rdata;
    steer_sel_t        sel;

    assign req_ready = !rsp_q.vld;
    assign fire      = req_valid && req_ready;
    assign hit_sel   = (req_addr == SEL_ADDR);
    assign hit_lock  = (req_addr == LOCK_ADDR);
    assign repl_off  = req_addr - REPL_BASE;
    assign hit_repl  = (req_addr >= REPL_BASE) && (int'(repl_off) < NUM_REGS);
    assign reg_idx   = REG_W'(repl_off);
    assign tgt_ok    = (int'(sel.grp) < NUM_GROUPS) && (int'(sel.inst) < NUM_INST);
    assign tgt_idx   = IDX_W'(int'(sel.grp) * NUM_INST + int'(sel.inst));

    repl_steer_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (fire),
        .wr         (req_write),
        .agent      (req_agent),
        .hit_sel    (hit_sel),
        .hit_lock   (hit_lock),
        .sel_wdata  (req_wdata[SEL_BITS-1:0]),
        .wdata_zero (req_wdata == '0),
        .sel        (sel),
        .lock_grant (lock_grant)
    );

    repl_store #(
        .NUM_REGS  (NUM_REGS),
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (DATA_W),
        .REG_W     (REG_W),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fire && req_write && hit_repl),
        .bcast   (sel.bcast),
        .reg_idx (reg_idx),
        .tgt_idx (tgt_idx),
        .tgt_ok  (tgt_ok),
        .avail   (avail_mask),
        .wdata   (req_wdata),
        .rdata   (store_rdata)
    );

    always_comb begin
        rsp_d.vld   = fire;
        rsp_d.rdata = '0;
        if (fire && !req_write) begin
            if (hit_sel)       rsp_d.rdata = DATA_W'(sel);
            else if (hit_lock) rsp_d.rdata = DATA_W'(lock_grant);
            else if (hit_repl) rsp_d.rdata = store_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_rdata = rsp_q.rdata;

    // R11
    rsp_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid);

    // R11
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    terminated_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !req_write && hit_repl && !(tgt_ok && avail_mask[tgt_idx])) |=> (rsp_rdata == '0));

    // R12
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !req_write && !hit_sel && !hit_lock && !hit_repl) |=> (rsp_rdata == '0));

endmodule

// File: tb/repl_reg_steer_test.sv
module repl_reg_steer_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 27;

    typedef struct packed {
        logic        ag;
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        chk;
        logic [3:0]  req;
    } vec_t;

    // avail mask: indices 5 (g1,i1) and 10 (g2,i2) unavailable
    localparam vec_t V [NV] = '{
        '{1'b0, 1'b0, 4'd1, 32'h0,        32'h1,        1'b1, 4'd8},  // R8 free -> granted
        '{1'b1, 1'b0, 4'd1, 32'h0,        32'h0,        1'b1, 4'd8},  // R8 held -> 0
        '{1'b1, 1'b1, 4'd0, 32'h43,       32'h0,        1'b0, 4'd10},
        '{1'b0, 1'b0, 4'd0, 32'h0,        32'h0,        1'b1, 4'd10}, // R10 non-owner write ignored
        '{1'b0, 1'b1, 4'd0, 32'h40,       32'h0,        1'b0, 4'd1},
        '{1'b0, 1'b0, 4'd0, 32'h0,        32'h40,       1'b1, 4'd1},  // R1
        '{1'b0, 1'b1, 4'd2, 32'hA5A50001, 32'h0,        1'b0, 4'd2},
        '{1'b0, 1'b0, 4'd2, 32'h0,        32'hA5A50001, 1'b1, 4'd4},  // R4 read under broadcast
        '{1'b0, 1'b1, 4'd0, 32'h09,       32'h0,        1'b0, 4'd5},
        '{1'b0, 1'b0, 4'd2, 32'h0,        32'h0,        1'b1, 4'd5},  // R5 unavailable
        '{1'b0, 1'b1, 4'd2, 32'h1234,     32'h0,        1'b0, 4'd6},
        '{1'b0, 1'b1, 4'd0, 32'h0B,       32'h0,        1'b0, 4'd3},
        '{1'b0, 1'b1, 4'd2, 32'hBEEF,     32'h0,        1'b0, 4'd3},
        '{1'b0, 1'b0, 4'd2, 32'h0,        32'hBEEF,     1'b1, 4'd3},  // R3
        '{1'b0, 1'b1, 4'd0, 32'h13,       32'h0,        1'b0, 4'd3},
        '{1'b0, 1'b0, 4'd2, 32'h0,        32'hA5A50001, 1'b1, 4'd3},  // R3 neighbour intact
        '{1'b0, 1'b0, 4'd3, 32'h0,        32'h0,        1'b1, 4'd12}, // R12 second register
        '{1'b0, 1'b1, 4'd0, 32'h04,       32'h0,        1'b0, 4'd5},
        '{1'b0, 1'b0, 4'd2, 32'h0,        32'h0,        1'b1, 4'd5},  // R5 group out of range
        '{1'b0, 1'b1, 4'd7, 32'hFFFF,     32'h0,        1'b0, 4'd12},
        '{1'b0, 1'b0, 4'd7, 32'h0,        32'h0,        1'b1, 4'd12}, // R12 unmapped
        '{1'b1, 1'b1, 4'd1, 32'h0,        32'h0,        1'b0, 4'd9},
        '{1'b1, 1'b0, 4'd1, 32'h0,        32'h0,        1'b1, 4'd9},  // R9 non-owner release ignored
        '{1'b0, 1'b1, 4'd1, 32'h0,        32'h0,        1'b0, 4'd9},
        '{1'b1, 1'b0, 4'd1, 32'h0,        32'h1,        1'b1, 4'd9},  // R9 owner released
        '{1'b0, 1'b1, 4'd0, 32'h00,       32'h0,        1'b0, 4'd10},
        '{1'b1, 1'b0, 4'd0, 32'h0,        32'h04,       1'b1, 4'd10}  // R10 old owner locked out
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_agent = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [15:0] avail_mask = 16'hFBDF;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    repl_reg_steer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_agent  (req_agent),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .avail_mask (avail_mask),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic ag, input logic wr, input logic [3:0] a,
                        input logic [31:0] d, output logic [31:0] r);
        @(negedge clk);
        check({31'b0, req_ready}, 32'h1, "R11 ready idle");
        req_valid = 1'b1; req_write = wr; req_agent = ag; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check({31'b0, rsp_valid}, 32'h1, "R11 response next cycle");
        r = rsp_rdata;
        @(negedge clk);
        check({31'b0, rsp_valid}, 32'h0, "R11 response one cycle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check({31'b0, rsp_valid}, 32'h0, "R11 reset rsp_valid");
        // R1 reset selector
        xfer(1'b0, 1'b0, 4'd0, 32'h0, rd);
        check(rd, 32'h0, "R1 reset selector");

        for (int i = 0; i < NV; i++) begin
            xfer(V[i].ag, V[i].wr, V[i].addr, V[i].wdata, rd);
            if (V[i].chk) check(rd, V[i].exp, $sformatf("R%0d vec %0d", V[i].req, i));
        end

        // agent 1 owns the lock now; open all instances
        avail_mask = 16'hFFFF;
        xfer(1'b1, 1'b1, 4'd0, 32'h09, rd);
        xfer(1'b1, 1'b0, 4'd2, 32'h0, rd);
        check(rd, 32'h0, "R6 dropped unicast write");
        xfer(1'b1, 1'b1, 4'd0, 32'h12, rd);
        xfer(1'b1, 1'b0, 4'd2, 32'h0, rd);
        check(rd, 32'h0, "R7 broadcast skipped gated copy");
        xfer(1'b1, 1'b1, 4'd0, 32'h52, rd);
        xfer(1'b1, 1'b1, 4'd3, 32'h77, rd);
        xfer(1'b1, 1'b1, 4'd0, 32'h0B, rd);
        xfer(1'b1, 1'b0, 4'd3, 32'h0, rd);
        check(rd, 32'h77, "R2 broadcast reached g3 i1");
        xfer(1'b1, 1'b1, 4'd0, 32'h09, rd);
        xfer(1'b1, 1'b0, 4'd3, 32'h0, rd);
        check(rd, 32'h77, "R2 broadcast reached g1 i1");
        xfer(1'b1, 1'b0, 4'd2, 32'h0, rd);
        check(rd, 32'h0, "R12 other register untouched");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule